// File: doc/BRIEF.md
# Command Ring Mailbox Decoder

This card-side block keeps a small ring of 32-bit command words in its register space. The host stores command words into ring slots and then moves a producer index forward. The block keeps its own consumer index. While the two indices differ, it fetches the slot the consumer index points at and splits the word into three fields: an 8-bit opcode, 12 bits of flags and a 12-bit argument. It offers these fields to an embedded consumer over a valid/ready handshake. When the consumer accepts an entry, the consumer index moves on by one, and the host can read it back.

A separate mailbox register handles the interrupt toward the host. The card raises a request, and a host write to the mailbox clears it. Bit 0 of the value written decides whether later requests are suppressed. After a synchronous reset, the block sweeps the whole ring to zero before it serves any entry. Executing the commands belongs to the consumer (for example, opcode 0x01 with flags 1 or 2 reports the host stack up or down, and opcode 0x0B starts link negotiation).

Top module: `cmdring_mailbox`

## Requirements
- R1: After reset the producer index (byte offset 0x50C) and the consumer index (0x62C) read as zero, `cmd_valid_o` and `irq_o` are low, and `init_busy_o` is high.
- R2: For 64 cycles after reset, `init_busy_o` stays high while every ring slot (0x700 + 4*slot) is written with zero. Host writes to ring slots during that time are dropped, and no entry is presented.
- R3: While the consumer index equals the producer index, no entry is presented (`cmd_valid_o` stays low).
- R4: A presented entry carries the opcode from word bits 31:24 on `cmd_code_o`, the flags from bits 23:12 on `cmd_flags_o` and the argument from bits 11:0 on `cmd_index_o`.
- R5: Entries are presented in ring order. Each cycle with `cmd_valid_o` and `cmd_ready_i` both high advances the consumer index by exactly one, and no other cycle changes it.
- R6: Both indices are 6 bits wide and wrap from 63 to 0. A producer write keeps only bits 5:0 of the data.
- R7: While `cmd_valid_o` is high and `cmd_ready_i` is low, valid and all three fields hold their values.
- R8: Host writes to the consumer index register have no effect.
- R9: A pulse on `irq_req_i` raises `irq_o` unless the mailbox mask is set. Any host write to the mailbox (0x504) clears `irq_o`. Write bit 0 = 1 sets the mask, 0 clears it, and the mask reads back at bit 0.
- R10: A producer write that laps the consumer is accepted as written and reads back unchanged. The block then serves entries up to that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the read strobe |
| irq_req_i | input | 1 | Card-side interrupt request pulse |
| irq_o | output | 1 | Interrupt toward the host |
| init_busy_o | output | 1 | High while the post-reset ring clear runs |
| cmd_valid_o | output | 1 | A decoded entry is presented |
| cmd_ready_i | input | 1 | Consumer accepts the entry |
| cmd_code_o | output | 8 | Opcode field |
| cmd_flags_o | output | 12 | Flags field |
| cmd_index_o | output | 12 | Argument field |

## Verification
The hardest case to reach from the ports is the wrap of both indices from slot 63 back to slot 0. The bench gets there by pushing and draining commands one at a time until the consumer has travelled well over a full lap, checking each word and the index read-back on the way. The clear sweep is proven through the handshake: the host bumps the producer over a slot it never wrote and expects an all-zero entry. The slot it tried to write during the sweep must also stay zero.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  typedef enum logic [1:0] {
    POP_IDLE  = 2'd0,
    POP_FETCH = 2'd1,
    POP_HOLD  = 2'd2
  } pop_state_e;

  localparam logic [7:0] OPC_HOST_STATE = 8'h01;
  localparam logic [7:0] OPC_LINK_NEG   = 8'h0B;
endpackage

// File: rtl/cmdring_mem.sv
module cmdring_mem #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/cmdring_mbox.sv
module cmdring_mbox (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wr_mask,
  input  logic req_i,
  output logic irq_o,
  output logic mask_o
);
  logic pend_q, mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (wr_hit) begin
        pend_q <= 1'b0;
        mask_q <= wr_mask;
      end else if (req_i && !mask_q) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign irq_o  = pend_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/cmdring_host.sv
module cmdring_host #(
  parameter int              ADDR_W    = 12,
  parameter int              DATA_W    = 32,
  parameter int              DEPTH     = 64,
  parameter logic [ADDR_W-1:0] RING_BASE = 12'h700,
  parameter logic [ADDR_W-1:0] PROD_OFS  = 12'h50C,
  parameter logic [ADDR_W-1:0] CONS_OFS  = 12'h62C,
  parameter logic [ADDR_W-1:0] MBOX_OFS  = 12'h504,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [IW-1:0]     cons_i,
  input  logic              mask_i,
  output logic [IW-1:0]     prod_o,
  output logic              mbox_hit_o,
  output logic              ram_we,
  output logic [IW-1:0]     ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              busy_o
);
  localparam int RING_BYTES = DEPTH * 4;
  localparam logic [ADDR_W:0] RING_END = {1'b0, RING_BASE} + RING_BYTES[ADDR_W:0];

  logic [IW-1:0]     prod_q;
  logic [IW-1:0]     sweep_q;
  logic              busy_q;
  logic [ADDR_W-1:0] ring_off;
  logic              ring_hit;

  assign ring_off = addr - RING_BASE;
  assign ring_hit = ({1'b0, addr} >= {1'b0, RING_BASE}) && ({1'b0, addr} < RING_END);

  // post-reset sweep that zeroes every slot
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b1;
      sweep_q <= '0;
    end else if (busy_q) begin
      sweep_q <= sweep_q + 1'b1;
      if (sweep_q == IW'(DEPTH - 1)) busy_q <= 1'b0;
    end
  end

  always_comb begin
    if (busy_q) begin
      ram_we    = 1'b1;
      ram_waddr = sweep_q;
      ram_wdata = '0;
    end else begin
      ram_we    = wr_en && ring_hit;
      ram_waddr = ring_off[IW+1:2];
      ram_wdata = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else if (wr_en && addr == PROD_OFS) prod_q <= wdata[IW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr == PROD_OFS)      rdata <= DATA_W'(prod_q);
      else if (addr == CONS_OFS) rdata <= DATA_W'(cons_i);
      else if (addr == MBOX_OFS) rdata <= DATA_W'(mask_i);
      else                       rdata <= '0;
    end
  end

  assign mbox_hit_o = wr_en && (addr == MBOX_OFS);
  assign prod_o     = prod_q;
  assign busy_o     = busy_q;
endmodule

// File: rtl/cmdring_pop.sv
module cmdring_pop
  import cmdring_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int CMD_W  = 8,
  parameter int FLG_W  = 12,
  parameter int ARG_W  = 12,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic [IW-1:0]     prod_i,
  output logic [IW-1:0]     cons_o,
  output logic              rd_en,
  output logic [IW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [CMD_W-1:0]  code_o,
  output logic [FLG_W-1:0]  flags_o,
  output logic [ARG_W-1:0]  arg_o
);
  localparam int ARG_LO = 0;
  localparam int FLG_LO = ARG_W;
  localparam int CMD_LO = ARG_W + FLG_W;

  pop_state_e    st_q;
  logic [IW-1:0] cons_q;

  assign rd_en   = (st_q == POP_IDLE) && !busy_i && (cons_q != prod_i);
  assign rd_addr = cons_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= POP_IDLE;
      cons_q  <= '0;
      valid_o <= 1'b0;
      code_o  <= '0;
      flags_o <= '0;
      arg_o   <= '0;
    end else begin
      case (st_q)
        POP_IDLE: if (rd_en) st_q <= POP_FETCH;
        POP_FETCH: begin
          code_o  <= rd_data[CMD_LO +: CMD_W];
          flags_o <= rd_data[FLG_LO +: FLG_W];
          arg_o   <= rd_data[ARG_LO +: ARG_W];
          valid_o <= 1'b1;
          st_q    <= POP_HOLD;
        end
        POP_HOLD: if (ready_i) begin
          valid_o <= 1'b0;
          cons_q  <= cons_q + 1'b1;
          st_q    <= POP_IDLE;
        end
        default: st_q <= POP_IDLE;
      endcase
    end
  end

  assign cons_o = cons_q;
endmodule

// File: rtl/cmdring_mailbox.sv
module cmdring_mailbox #(
  parameter int                ADDR_W    = 12,
  parameter int                DATA_W    = 32,
  parameter int                DEPTH     = 64,
  parameter int                CMD_W     = 8,
  parameter int                FLG_W     = 12,
  parameter int                ARG_W     = 12,
  parameter logic [ADDR_W-1:0] RING_BASE = 12'h700,
  parameter logic [ADDR_W-1:0] PROD_OFS  = 12'h50C,
  parameter logic [ADDR_W-1:0] CONS_OFS  = 12'h62C,
  parameter logic [ADDR_W-1:0] MBOX_OFS  = 12'h504
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              irq_req_i,
  output logic              irq_o,
  output logic              init_busy_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [CMD_W-1:0]  cmd_code_o,
  output logic [FLG_W-1:0]  cmd_flags_o,
  output logic [ARG_W-1:0]  cmd_index_o
);
  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0]     prod_idx, cons_idx;
  logic              mask, mbox_hit;
  logic              ram_we, ram_re;
  logic [IW-1:0]     ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  cmdring_host #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .RING_BASE(RING_BASE),
    .PROD_OFS(PROD_OFS), .CONS_OFS(CONS_OFS), .MBOX_OFS(MBOX_OFS)
  ) u_host (
    .clk(clk), .rst(rst), .wr_en(host_wr_en), .rd_en(host_rd_en),
    .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata),
    .cons_i(cons_idx), .mask_i(mask), .prod_o(prod_idx), .mbox_hit_o(mbox_hit),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .busy_o(init_busy_o)
  );

  cmdring_mbox u_mbox (
    .clk(clk), .rst(rst), .wr_hit(mbox_hit), .wr_mask(host_wdata[0]),
    .req_i(irq_req_i), .irq_o(irq_o), .mask_o(mask)
  );

  cmdring_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  cmdring_pop #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .CMD_W(CMD_W), .FLG_W(FLG_W), .ARG_W(ARG_W)
  ) u_pop (
    .clk(clk), .rst(rst), .busy_i(init_busy_o), .prod_i(prod_idx),
    .cons_o(cons_idx), .rd_en(ram_re), .rd_addr(ram_raddr), .rd_data(ram_rdata),
    .valid_o(cmd_valid_o), .ready_i(cmd_ready_i), .code_o(cmd_code_o),
    .flags_o(cmd_flags_o), .arg_o(cmd_index_o)
  );
endmodule

// File: rtl/cmdring_checker.sv
module cmdring_checker #(
  parameter int                ADDR_W   = 12,
  parameter int                IW       = 6,
  parameter int                CMD_W    = 8,
  parameter int                FLG_W    = 12,
  parameter int                ARG_W    = 12,
  parameter logic [ADDR_W-1:0] MBOX_OFS = 12'h504
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr_en,
  input logic [ADDR_W-1:0] host_addr,
  input logic              valid,
  input logic              ready,
  input logic [CMD_W-1:0]  code,
  input logic [FLG_W-1:0]  flags,
  input logic [ARG_W-1:0]  arg,
  input logic [IW-1:0]     cons,
  input logic [IW-1:0]     prod,
  input logic              irq,
  input logic              busy
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid && !irq && cons == '0 && prod == '0)); // R1

  AST_SWEEP_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    busy |-> !valid); // R2

  AST_RISE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(cons != prod, 2)); // R3

  AST_CONS_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid && ready) |=> (cons == $past(cons) + 1'b1)); // R5

  AST_CONS_STILL: assert property (@(posedge clk) disable iff (rst)
    !(valid && ready) |=> $stable(cons)); // R5

  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(code) && $stable(flags) && $stable(arg))); // R7

  AST_MBOX_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && host_addr == MBOX_OFS) |=> !irq); // R9
endmodule

bind cmdring_mailbox cmdring_checker #(
  .ADDR_W(ADDR_W), .IW($clog2(DEPTH)), .CMD_W(CMD_W), .FLG_W(FLG_W),
  .ARG_W(ARG_W), .MBOX_OFS(MBOX_OFS)
) u_chk (
  .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_addr(host_addr),
  .valid(cmd_valid_o), .ready(cmd_ready_i), .code(cmd_code_o),
  .flags(cmd_flags_o), .arg(cmd_index_o), .cons(cons_idx), .prod(prod_idx),
  .irq(irq_o), .busy(init_busy_o)
);

// File: tb/cmdring_mailbox_bench.sv
`timescale 1ns/1ps
module cmdring_mailbox_bench;
  localparam logic [11:0] RING = 12'h700;
  localparam logic [11:0] PROD = 12'h50C;
  localparam logic [11:0] CONS = 12'h62C;
  localparam logic [11:0] MBOX = 12'h504;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        irq_req_i = 1'b0, irq_o, init_busy_o;
  logic        cmd_valid_o, cmd_ready_i = 1'b0;
  logic [7:0]  cmd_code_o;
  logic [11:0] cmd_flags_o, cmd_index_o;

  int n_chk = 0, n_bad = 0;
  int cons_m = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmdring_mailbox u_cmdring_mailbox (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_req_i(irq_req_i), .irq_o(irq_o), .init_busy_o(init_busy_o),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_code_o(cmd_code_o),
    .cmd_flags_o(cmd_flags_o), .cmd_index_o(cmd_index_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rdata;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    irq_req_i = 1'b1;
    @(negedge clk);
    irq_req_i = 1'b0;
  endtask

  // wait for an entry, optionally stall, check fields, then accept it
  task automatic pop_expect(string tag, logic [31:0] exp, int stall);
    int w = 0;
    logic [31:0] got;
    while (!cmd_valid_o && w < 50) begin @(negedge clk); w++; end
    chk({tag, " valid"}, 32'(cmd_valid_o), 32'd1);
    got = {cmd_code_o, cmd_flags_o, cmd_index_o};
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R7 held entry", {cmd_code_o, cmd_flags_o, cmd_index_o}, got);
      chk("R7 held valid", 32'(cmd_valid_o), 32'd1);
    end
    chk({tag, " code R4"},  32'(cmd_code_o),  32'(exp[31:24]));
    chk({tag, " flags R4"}, 32'(cmd_flags_o), 32'(exp[23:12]));
    chk({tag, " index R4"}, 32'(cmd_index_o), 32'(exp[11:0]));
    cmd_ready_i = 1'b1;
    @(negedge clk);
    cmd_ready_i = 1'b0;
    cons_m = (cons_m + 1) % 64;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 valid low", 32'(cmd_valid_o), 32'd0);
    chk("R1 irq low", 32'(irq_o), 32'd0);
    chk("R1 busy high", 32'(init_busy_o), 32'd1);
    rd(PROD, d); chk("R1 producer zero", d, 32'd0);
    rd(CONS, d); chk("R1 consumer zero", d, 32'd0);
  endtask

  task automatic t_sweep();
    logic [31:0] d;
    wr(RING, 32'hFFFF_FFFF);          // dropped during the clear (R2)
    while (init_busy_o) @(negedge clk);
    repeat (8) @(negedge clk);
    chk("R3 empty ring idle", 32'(cmd_valid_o), 32'd0);
    wr(PROD, 32'd1);
    pop_expect("R2 cleared slot0", 32'h0, 0);
    rd(CONS, d); chk("R5 consumer after one", d, 32'd1);
    repeat (6) @(negedge clk);
    chk("R3 idle once drained", 32'(cmd_valid_o), 32'd0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(RING + 12'd4,  32'h0100_1000);   // host-up command
    wr(RING + 12'd8,  32'h0B00_0000);   // link negotiation
    wr(RING + 12'd12, 32'hA5AB_C123);
    wr(PROD, 32'd4);
    pop_expect("R5 first", 32'h0100_1000, 5);
    pop_expect("R5 second", 32'h0B00_0000, 0);
    pop_expect("R5 third", 32'hA5AB_C123, 3);
    rd(CONS, d); chk("R5 consumer after three", d, 32'd4);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    for (int k = 0; k < 66; k++) begin
      logic [31:0] v;
      v = {8'(k + 3), 12'(k * 37), 12'(4095 - k)};
      wr(RING + 12'(cons_m * 4), v);
      wr(PROD, 32'((cons_m + 1) % 64));
      pop_expect("R6 wrap", v, 0);
    end
    rd(CONS, d); chk("R6 consumer after wrap", d, 32'(cons_m));
    wr(PROD, 32'h40 | 32'(cons_m));
    rd(PROD, d); chk("R6 producer keeps low bits", d, 32'(cons_m));
    repeat (6) @(negedge clk);
    chk("R6 no entry when equal", 32'(cmd_valid_o), 32'd0);
  endtask

  task automatic t_cons_ro();
    logic [31:0] d;
    wr(CONS, 32'h3F ^ 32'(cons_m));
    rd(CONS, d); chk("R8 consumer unchanged", d, 32'(cons_m));
    repeat (6) @(negedge clk);
    chk("R8 no entry after write", 32'(cmd_valid_o), 32'd0);
  endtask

  task automatic t_mbox();
    logic [31:0] d;
    pulse_req();
    chk("R9 request raises irq", 32'(irq_o), 32'd1);
    wr(MBOX, 32'd0);
    chk("R9 write clears irq", 32'(irq_o), 32'd0);
    wr(MBOX, 32'd1);
    rd(MBOX, d); chk("R9 mask reads back", d, 32'd1);
    pulse_req();
    chk("R9 masked request dropped", 32'(irq_o), 32'd0);
    wr(MBOX, 32'd0);
    rd(MBOX, d); chk("R9 unmask reads back", d, 32'd0);
    pulse_req();
    chk("R9 unmasked request", 32'(irq_o), 32'd1);
    wr(MBOX, 32'd1);
    chk("R9 masking write clears", 32'(irq_o), 32'd0);
    wr(MBOX, 32'd0);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    int target;
    target = (cons_m + 63) % 64;
    wr(RING + 12'(cons_m * 4), 32'h0B00_2007);
    wr(PROD, 32'(target));
    rd(PROD, d); chk("R10 lapped producer kept", d, 32'(target));
    pop_expect("R10 serve after lap", 32'h0B00_2007, 0);
    rd(CONS, d); chk("R10 consumer moves", d, 32'(cons_m));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sweep();
    t_fields();
    t_wrap();
    t_cons_ro();
    t_mbox();
    t_overrun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule